// File: doc/BRIEF.md
# Configurable Chain Magnitude Comparator

This block compares two unsigned operands and reports a single comparison bit. The kind of comparison is not fixed in hardware: three control constants (one for "above", one for "below", one for "equal") are fed into a chain that runs from the least significant bit position to the most significant. The equal constant seeds the bottom of the chain. At each bit position the chain value is carried upward untouched when the two operand bits agree, and is replaced by the "above" or "below" constant when they disagree. The value that leaves the top of the chain therefore reflects the most significant differing bit, or the equal constant when there is none.

Choosing the three constants selects any of the six ordering relations, or a constant 0 or 1. With only the "below" constant set, the chain is exactly the borrow path of a subtractor computing A minus B. Every intermediate chain value is also brought out, so tap i tells how the low i bits of the operands compare under the chosen relation.

The chain can be built as a plain ripple or with group bypass, where a group of bit positions whose operand bits all agree hands its incoming value straight to the next group. Both forms give identical results on every pin. The block is purely combinational; it has no clock, no registers and no handshake, and its control pins are plain levels.

Top module: `magcmp_chain`

## Requirements
- R1: Tap 0 always equals the equal control `ctl_eq`.
- R2: For each bit i, when `opa[i]` equals `opb[i]`, the chain value above that bit (tap i+1, or `result` for the top bit) equals tap i.
- R3: For each bit i, when `opa[i]`=1 and `opb[i]`=0, the chain value above that bit equals `ctl_gt`.
- R4: For each bit i, when `opa[i]`=0 and `opb[i]`=1, the chain value above that bit equals `ctl_lt`.
- R5: `result` is set by the most significant differing bit pair; for equal operands it equals `ctl_eq`. Tap i equals the comparison of the low i bits of the operands under the same controls.
- R6: With controls written as (`ctl_gt`,`ctl_lt`,`ctl_eq`): 001 gives A=B, 110 gives A≠B, 100 gives A>B, 010 gives A<B, 101 gives A≥B, 011 gives A≤B.
- R7: Controls 000 force `result` to 0 and controls 111 force it to 1, for any operands.
- R8: With controls 010, `result` equals the borrow out of the unsigned subtraction A−B.
- R9: The group-bypass build (`USE_SKIP`=1) and the plain ripple build (`USE_SKIP`=0) produce identical `result` and `taps` for the same inputs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| opa | input | WIDTH | Operand A, unsigned |
| opb | input | WIDTH | Operand B, unsigned |
| ctl_gt | input | 1 | Constant placed in the chain where A's bit is 1 and B's is 0 |
| ctl_lt | input | 1 | Constant placed in the chain where A's bit is 0 and B's is 1 |
| ctl_eq | input | 1 | Constant seeding the bottom of the chain |
| taps | output | WIDTH | Chain values below each bit position; tap 0 is the seed |
| result | output | 1 | Chain value above the most significant bit |

## Verification
Every output of this block is combinational, so each result is due in the same cycle as the stimulus that causes it, with no register in the path. The bench changes operands and controls just after a falling clock edge and samples `result` and all taps a fixed 2 ns later, well before the next rising edge, so each check sees settled values of the current stimulus only. Expected values come from integer comparisons of the full operands and of their masked low parts, and a second instance built as a plain ripple is compared pin for pin with the bypass build.

// File: rtl/magcmp_pkg.sv
package magcmp_pkg;

  // Classification of one operand bit pair as seen by the chain.
  typedef enum logic [1:0] {
    PAIR_PASS  = 2'b00,  // bits agree: carry chain value upward
    PAIR_ABOVE = 2'b01,  // A bit 1, B bit 0: insert the "above" constant
    PAIR_BELOW = 2'b10   // A bit 0, B bit 1: insert the "below" constant
  } pair_kind_e;

  function automatic pair_kind_e classify_pair(input logic a, input logic b);
    if (a == b)  return PAIR_PASS;
    else if (a)  return PAIR_ABOVE;
    else         return PAIR_BELOW;
  endfunction

endpackage

// File: rtl/magcmp_slice.sv
module magcmp_slice
  import magcmp_pkg::*;
(
  input  logic a_bit,
  input  logic b_bit,
  input  logic k_above,
  input  logic k_below,
  input  logic chain_in,
  output logic chain_out
);

  pair_kind_e kind;

  always_comb begin
    kind = classify_pair(a_bit, b_bit);
    unique case (kind)
      PAIR_ABOVE: chain_out = k_above;
      PAIR_BELOW: chain_out = k_below;
      default:    chain_out = chain_in;
    endcase
  end

  // Slice-level checks tied to the operand bits, not to the internal kind.
  always_comb begin
    if (!$isunknown({a_bit, b_bit, k_above, k_below, chain_in})) begin
      if (a_bit == b_bit)
        a_r2_pass_on_match: assert (chain_out == chain_in)
          else $error("R2: slice did not pass chain on matching bits");
      if (a_bit && !b_bit)
        a_r3_above_inserted: assert (chain_out == k_above)
          else $error("R3: slice did not insert above constant");
      if (!a_bit && b_bit)
        a_r4_below_inserted: assert (chain_out == k_below)
          else $error("R4: slice did not insert below constant");
    end
  end

endmodule

// File: rtl/magcmp_group.sv
module magcmp_group #(
  parameter int GW       = 4,
  parameter bit USE_SKIP = 1'b1
) (
  input  logic [GW-1:0] a_grp,
  input  logic [GW-1:0] b_grp,
  input  logic          k_above,
  input  logic          k_below,
  input  logic          grp_in,
  output logic [GW-1:0] grp_taps,
  output logic          grp_out
);

  logic [GW:0] ripple;
  logic        all_match;

  assign ripple[0] = grp_in;

  for (genvar j = 0; j < GW; j++) begin : g_slice
    magcmp_slice u_slice (
      .a_bit     (a_grp[j]),
      .b_bit     (b_grp[j]),
      .k_above   (k_above),
      .k_below   (k_below),
      .chain_in  (ripple[j]),
      .chain_out (ripple[j+1])
    );
  end

  assign all_match = (a_grp == b_grp);

  if (USE_SKIP) begin : g_bypass
    // A fully matching group hands its input straight across.
    assign grp_out = all_match ? grp_in : ripple[GW];
  end else begin : g_ripple
    assign grp_out = ripple[GW];
  end

  if (GW > 1) begin : g_inner_taps
    assign grp_taps = {grp_out, ripple[GW-1:1]};
  end else begin : g_single_tap
    assign grp_taps = grp_out;
  end

  always_comb begin
    if (!$isunknown({a_grp, b_grp, k_above, k_below, grp_in})) begin
      if (all_match)
        a_r9_group_bypass_same: assert (grp_out == grp_in)
          else $error("R9: matching group changed the chain value");
      a_r9_bypass_equals_ripple: assert (grp_out == ripple[GW])
        else $error("R9: group output differs from ripple path");
    end
  end

endmodule

// File: rtl/magcmp_chain.sv
module magcmp_chain #(
  parameter int WIDTH    = 16,
  parameter int GROUP    = 4,
  parameter bit USE_SKIP = 1'b1
) (
  input  logic [WIDTH-1:0] opa,
  input  logic [WIDTH-1:0] opb,
  input  logic             ctl_gt,
  input  logic             ctl_lt,
  input  logic             ctl_eq,
  output logic [WIDTH-1:0] taps,
  output logic             result
);

  localparam int NGRP = WIDTH / GROUP;

  logic [WIDTH:0] chain;

  assign chain[0] = ctl_eq;

  for (genvar g = 0; g < NGRP; g++) begin : g_grp
    localparam int LO = g * GROUP;
    magcmp_group #(
      .GW       (GROUP),
      .USE_SKIP (USE_SKIP)
    ) u_grp (
      .a_grp    (opa[LO +: GROUP]),
      .b_grp    (opb[LO +: GROUP]),
      .k_above  (ctl_gt),
      .k_below  (ctl_lt),
      .grp_in   (chain[LO]),
      .grp_taps (chain[LO+1 +: GROUP]),
      .grp_out  ()
    );
  end

  assign taps   = chain[WIDTH-1:0];
  assign result = chain[WIDTH];

  initial begin
    a_cfg_group_divides: assert (GROUP > 0 && (WIDTH % GROUP) == 0)
      else $error("GROUP must divide WIDTH");
  end

  always_comb begin
    if (!$isunknown({opa, opb, ctl_gt, ctl_lt, ctl_eq})) begin
      a_r1_seed_tap: assert (taps[0] == ctl_eq)
        else $error("R1: tap 0 differs from equal control");
      if (opa == opb)
        a_r5_equal_gives_eq: assert (result == ctl_eq)
          else $error("R5: equal operands did not yield equal control");
      if (!ctl_gt && !ctl_lt && !ctl_eq)
        a_r7_all_zero: assert (result == 1'b0)
          else $error("R7: all-zero controls gave 1");
      if (ctl_gt && ctl_lt && ctl_eq)
        a_r7_all_one: assert (result == 1'b1)
          else $error("R7: all-one controls gave 0");
      if (!ctl_gt && ctl_lt && !ctl_eq)
        a_r8_borrow: assert (result == (opa < opb))
          else $error("R8: below-only controls differ from borrow");
    end
  end

endmodule

// File: tb/magcmp_chain_bench.sv
module magcmp_chain_bench;

  localparam int W = 16;

  logic         clk = 1'b0;
  logic [W-1:0] opa, opb;
  logic         ctl_gt, ctl_lt, ctl_eq;
  logic [W-1:0] taps, taps_rip;
  logic         result, result_rip;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 0;

  always #2.5 clk = ~clk;   // 200 MHz

  magcmp_chain #(.WIDTH(W), .GROUP(4), .USE_SKIP(1'b1)) u_magcmp_chain (
    .opa(opa), .opb(opb), .ctl_gt(ctl_gt), .ctl_lt(ctl_lt), .ctl_eq(ctl_eq),
    .taps(taps), .result(result)
  );

  magcmp_chain #(.WIDTH(W), .GROUP(4), .USE_SKIP(1'b0)) u_magcmp_chain_rip (
    .opa(opa), .opb(opb), .ctl_gt(ctl_gt), .ctl_lt(ctl_lt), .ctl_eq(ctl_eq),
    .taps(taps_rip), .result(result_rip)
  );

  // Operand pairs {A, B}
  localparam logic [2*W-1:0] VEC [16] = '{
    {16'h0000, 16'h0000}, {16'hFFFF, 16'hFFFF}, {16'h0001, 16'h0000},
    {16'h0000, 16'h0001}, {16'h8000, 16'h7FFF}, {16'h7FFF, 16'h8000},
    {16'h1234, 16'h1234}, {16'h1234, 16'h1235}, {16'hABCD, 16'hABCC},
    {16'h00F0, 16'h000F}, {16'hF000, 16'hF001}, {16'h5555, 16'hAAAA},
    {16'hAAAA, 16'h5555}, {16'h0F0F, 16'h0F0F}, {16'hFFFE, 16'hFFFF},
    {16'h8001, 16'h8000}
  };

  function automatic logic ref_cmp(input logic [W-1:0] a, input logic [W-1:0] b,
                                   input logic [2:0] c);
    // c = {gt, lt, eq}
    return (c[2] && (a > b)) || (c[1] && (a < b)) || (c[0] && (a == b));
  endfunction

  function automatic logic [W-1:0] ref_taps(input logic [W-1:0] a,
                                            input logic [W-1:0] b,
                                            input logic [2:0] c);
    logic [W-1:0] t;
    for (int i = 0; i < W; i++) begin
      logic [W-1:0] m;
      m = (W'(1) << i) - W'(1);
      t[i] = ref_cmp(a & m, b & m, c);
    end
    return t;
  endfunction

  task automatic check(input string tag, input logic [W:0] got, input logic [W:0] exp);
    n_tests++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h (A=%h B=%h ctl=%b%b%b)",
               tag, got, exp, opa, opb, ctl_gt, ctl_lt, ctl_eq);
    end
  endtask

  task automatic apply(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] c);
    @(negedge clk);
    opa = a; opb = b; {ctl_gt, ctl_lt, ctl_eq} = c;
    #2;
  endtask

  // Full check of one stimulus: R5 result and taps, R1 seed, R9 equivalence.
  task automatic full_check(input logic [W-1:0] a, input logic [W-1:0] b, input logic [2:0] c);
    apply(a, b, c);
    check("R5 result", {W'(0), result}, {W'(0), ref_cmp(a, b, c)});
    check("R5 taps", {1'b0, taps}, {1'b0, ref_taps(a, b, c)});
    check("R1 tap0", {W'(0), taps[0]}, {W'(0), c[0]});
    check("R9 ripple vs bypass", {result_rip, taps_rip}, {result, taps});
  endtask

  initial begin
    opa = '0; opb = '0; {ctl_gt, ctl_lt, ctl_eq} = 3'b000;
    repeat (2) @(posedge clk);

    // Initial state: zero operands, zero controls -> 0 (R7)
    #1;
    check("R7 initial zero", {W'(0), result}, '0);

    // Table walk over all eight control settings (R6, R5)
    for (int v = 0; v < 16; v++) begin
      for (int c = 0; c < 8; c++) begin
        full_check(VEC[v][2*W-1:W], VEC[v][W-1:0], 3'(c));
      end
    end

    // Random operands, plus equal random operands
    for (int r = 0; r < 200; r++) begin
      logic [W-1:0] ra, rb;
      ra = W'($urandom);
      rb = (r % 4 == 0) ? ra : W'($urandom);
      for (int c = 0; c < 8; c++) full_check(ra, rb, 3'(c));
    end

    // R6 named relations
    apply(16'h0010, 16'h0010, 3'b001); check("R6 eq", {W'(0), result}, {W'(0), 1'b1});
    apply(16'h0010, 16'h0011, 3'b110); check("R6 ne", {W'(0), result}, {W'(0), 1'b1});
    apply(16'h0100, 16'h00FF, 3'b100); check("R6 gt", {W'(0), result}, {W'(0), 1'b1});
    apply(16'h00FF, 16'h0100, 3'b010); check("R6 lt", {W'(0), result}, {W'(0), 1'b1});
    apply(16'h4000, 16'h4000, 3'b101); check("R6 ge", {W'(0), result}, {W'(0), 1'b1});
    apply(16'h4001, 16'h4000, 3'b011); check("R6 le", {W'(0), result}, {W'(0), 1'b0});

    // R7 forced outputs
    apply(16'hFFFF, 16'h0000, 3'b000); check("R7 all zero", {W'(0), result}, '0);
    apply(16'h0000, 16'hFFFF, 3'b111); check("R7 all one", {W'(0), result}, {W'(0), 1'b1});

    // R8 borrow of A-B
    for (int k = 0; k < 20; k++) begin
      logic [W-1:0] ra, rb;
      logic [W:0] diff;
      ra = W'($urandom); rb = W'($urandom);
      diff = {1'b0, ra} - {1'b0, rb};
      apply(ra, rb, 3'b010);
      check("R8 borrow", {W'(0), result}, {W'(0), diff[W]});
    end

    // R2/R3/R4 per-bit: single differing bit at position p
    for (int p = 0; p < W; p++) begin
      logic [W-1:0] bit_p;
      bit_p = W'(1) << p;
      // A has the bit (R3): above p chain = gt, below = eq
      apply(bit_p, '0, 3'b100);
      check("R3 insert above", {result, taps},
            {1'b1, ((p + 1 < W) ? ~((W'(1) << (p + 1)) - W'(1)) : W'(0))});
      // B has the bit (R4)
      apply('0, bit_p, 3'b010);
      check("R4 insert below", {result, taps},
            {1'b1, ((p + 1 < W) ? ~((W'(1) << (p + 1)) - W'(1)) : W'(0))});
    end
    // R2: all bits match, seed propagates everywhere
    apply(16'h3C5A, 16'h3C5A, 3'b001);
    check("R2 pass all", {result, taps}, {1'b1, {W{1'b1}}});
    apply(16'h3C5A, 16'h3C5A, 3'b110);
    check("R2 pass zero", {result, taps}, '0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule